// File: doc/BRIEF.md
# Event-Armed Bit-Time Compare Timer

This block is a compare timer that sits beside a serial port. A serial-line event, chosen by a start selector, arms a comparator and clears its counter. While armed, the counter advances by one on every cycle in which the bit-time tick input is high. When a tick arrives while the count equals the programmed compare value, the block issues a one-cycle compare pulse.

A second selector picks what disarms the comparator. It can be the match itself, the start of a transmit, or an edge on the receive line. An optional restart mode clears the counter on every match and keeps it running, which gives a periodic pulse measured in bit times. The whole setup is one 32-bit configuration word. Every write of that word disarms the timer.

Top module: `evtrig_cmp_timer`

## Requirements
- R1: Configuration word layout: compare value in bits 7:0, start selector in bits 18:16, stop selector in bits 22:20, restart enable in bit 24. After reset all of them are zero, the comparator is disarmed and `cmp_pulse` is low.
- R2: Start selector codes: 1 arms on `ev_tx_eof`, 2 on `ev_tx_done`, 3 on `ev_rx_active`, 4 on `ev_rx_eof`. Events that are not selected do not arm the comparator.
- R3: Stop selector codes: 1 disarms on `ev_tx_start`, 2 on `ev_rx_active`, 3 on `ev_rx_idle`. Events that are not selected do not disarm it. Codes 4 to 7 have no stop event.
- R4: The counter advances only on cycles where `bit_tick` is high while the comparator is armed. Otherwise it holds its value.
- R5: A tick that arrives while armed, with the count equal to the compare value, makes `cmp_pulse` high for one cycle after that clock edge.
- R6: With restart enable set, each compare event clears the counter to zero and the comparator stays armed.
- R7: With stop code 0 and restart clear, the comparator disarms at the same edge that raises the pulse. With any other stop code and restart clear, it stays armed and the 8-bit counter wraps, so the next pulse comes 256 ticks later.
- R8: A start event and a stop event in the same cycle leave the comparator disarmed.
- R9: A start event that arrives while the comparator is already armed clears the counter and keeps it armed.
- R10: A configuration write disarms the comparator and clears the counter.
- R11: Start code 0, and the unused codes 5 to 7, never arm the comparator, so no compare pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| ev_tx_eof | input | 1 | Transmit end-of-frame strobe |
| ev_tx_done | input | 1 | Transmit complete strobe |
| ev_tx_start | input | 1 | Transmit start strobe |
| ev_rx_active | input | 1 | Receive line became active |
| ev_rx_idle | input | 1 | Receive line became inactive |
| ev_rx_eof | input | 1 | Receive end-of-frame strobe |
| bit_tick | input | 1 | Bit-time tick |
| cmp_pulse | output | 1 | One-cycle compare event |

## Verification
The assertions assume that the event strobes and `bit_tick` are synchronous, one-cycle-wide inputs that are known from reset onward, and that a configuration write is a single-cycle strobe. None of them assumes that events are mutually exclusive. The bench drives every input at the falling edge and holds each strobe high for exactly one cycle. It deliberately raises a start and a stop in the same cycle, and it mixes tick bursts with idle cycles, so the priority and hold properties are exercised.

// File: rtl/evtrig_cmp_pkg.sv
package evtrig_cmp_pkg;
  localparam int CMP_W = 8;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic             restart;
    logic [SEL_W-1:0] stop_sel;
    logic [SEL_W-1:0] start_sel;
    logic [CMP_W-1:0] cmp_val;
  } cfg_t;

  // field placement within the 32-bit configuration word
  function automatic cfg_t cfg_unpack(input logic [31:0] w);
    cfg_t c;
    c.restart   = w[24];
    c.stop_sel  = w[22:20];
    c.start_sel = w[18:16];
    c.cmp_val   = w[CMP_W-1:0];
    return c;
  endfunction

  function automatic logic cmp_hit(input logic [CMP_W-1:0] cnt,
                                   input logic [CMP_W-1:0] val);
    return cnt == val;
  endfunction

  function automatic logic [CMP_W-1:0] cnt_step(input logic [CMP_W-1:0] cnt);
    return cnt + 1'b1;
  endfunction
endpackage

// File: rtl/evtrig_evt_select.sv
module evtrig_evt_select #(
  parameter int SEL_W = 3,
  localparam int N_SRC = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [N_SRC-1:0] events,
  output logic             hit
);
  logic [N_SRC-1:0] gated;
  genvar i;
  generate
    for (i = 0; i < N_SRC; i++) begin : g_src
      assign gated[i] = events[i] && (sel == SEL_W'(i));
    end
  endgenerate
  assign hit = |gated;
endmodule

// File: rtl/evtrig_counter.sv
module evtrig_counter
  import evtrig_cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start_hit,
  input  logic             stop_hit,
  input  logic             tick,
  input  logic             restart_en,
  input  logic             self_stop,
  input  logic [CMP_W-1:0] cmp_val,
  output logic             armed,
  output logic [CMP_W-1:0] count,
  output logic             cmp_evt
);
  assign cmp_evt = armed && tick && cmp_hit(count, cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      count <= '0;
    end else if (clr) begin
      armed <= 1'b0;
      count <= '0;
    end else if (stop_hit) begin
      armed <= 1'b0;
    end else if (start_hit) begin
      armed <= 1'b1;
      count <= '0;
    end else if (armed && tick) begin
      if (cmp_evt && restart_en) begin
        count <= '0;
      end else if (cmp_evt && self_stop) begin
        armed <= 1'b0;
      end else begin
        count <= cnt_step(count);
      end
    end
  end
endmodule

// File: rtl/evtrig_cmp_timer.sv
module evtrig_cmp_timer
  import evtrig_cmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  input  logic        ev_tx_eof,
  input  logic        ev_tx_done,
  input  logic        ev_tx_start,
  input  logic        ev_rx_active,
  input  logic        ev_rx_idle,
  input  logic        ev_rx_eof,
  input  logic        bit_tick,
  output logic        cmp_pulse
);
  localparam int N_SRC = 1 << SEL_W;

  cfg_t             cfg_q;
  logic [N_SRC-1:0] start_vec;
  logic [N_SRC-1:0] stop_vec;
  logic             start_hit;
  logic             stop_hit;
  logic             armed;
  logic [CMP_W-1:0] count;
  logic             cmp_evt;
  logic             self_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_unpack(cfg_wdata);
  end

  // code 0 carries no event on either side
  always_comb begin
    start_vec    = '0;
    start_vec[1] = ev_tx_eof;
    start_vec[2] = ev_tx_done;
    start_vec[3] = ev_rx_active;
    start_vec[4] = ev_rx_eof;
    stop_vec     = '0;
    stop_vec[1]  = ev_tx_start;
    stop_vec[2]  = ev_rx_active;
    stop_vec[3]  = ev_rx_idle;
  end

  assign self_stop = (cfg_q.stop_sel == '0);

  evtrig_evt_select #(.SEL_W(SEL_W)) u_start_sel (
    .sel(cfg_q.start_sel), .events(start_vec), .hit(start_hit)
  );

  evtrig_evt_select #(.SEL_W(SEL_W)) u_stop_sel (
    .sel(cfg_q.stop_sel), .events(stop_vec), .hit(stop_hit)
  );

  evtrig_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cfg_we),
    .start_hit(start_hit), .stop_hit(stop_hit), .tick(bit_tick),
    .restart_en(cfg_q.restart), .self_stop(self_stop),
    .cmp_val(cfg_q.cmp_val),
    .armed(armed), .count(count), .cmp_evt(cmp_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_pulse <= 1'b0;
    else cmp_pulse <= cmp_evt && !cfg_we;
  end
endmodule

// File: rtl/evtrig_cmp_timer_chk.sv
module evtrig_cmp_timer_chk
  import evtrig_cmp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             bit_tick,
  input logic             cmp_pulse,
  input logic             armed,
  input logic [CMP_W-1:0] count,
  input logic             cmp_evt,
  input logic             start_hit,
  input logic             stop_hit,
  input cfg_t             cfg_q
);
  assert_cfg_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!armed && count == '0));

  assert_stop_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> !armed);

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !start_hit && !stop_hit && !cfg_we) |=> $stable(count));

  assert_pulse_needs_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |-> $past(armed && bit_tick));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && cfg_q.restart && !cfg_we && !stop_hit) |=> (armed && count == '0));

  assert_self_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && cfg_q.stop_sel == '0 && !cfg_q.restart && !start_hit && !cfg_we)
      |=> (!armed && cmp_pulse));

  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !cfg_we && (cfg_q.start_sel == '0 || cfg_q.start_sel > 3'd4))
      |=> !armed);

  assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && start_hit && !stop_hit && !cfg_we) |=> (armed && count == '0));
endmodule

bind evtrig_cmp_timer evtrig_cmp_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .bit_tick(bit_tick),
  .cmp_pulse(cmp_pulse), .armed(armed), .count(count), .cmp_evt(cmp_evt),
  .start_hit(start_hit), .stop_hit(stop_hit), .cfg_q(cfg_q)
);

// File: tb/evtrig_cmp_timer_tb.sv
module evtrig_cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        ev_tx_eof = 1'b0, ev_tx_done = 1'b0, ev_tx_start = 1'b0;
  logic        ev_rx_active = 1'b0, ev_rx_idle = 1'b0, ev_rx_eof = 1'b0;
  logic        bit_tick = 1'b0;
  logic        cmp_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  evtrig_cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ev_tx_eof(ev_tx_eof), .ev_tx_done(ev_tx_done), .ev_tx_start(ev_tx_start),
    .ev_rx_active(ev_rx_active), .ev_rx_idle(ev_rx_idle), .ev_rx_eof(ev_rx_eof),
    .bit_tick(bit_tick), .cmp_pulse(cmp_pulse)
  );

  function automatic logic [31:0] mk(int start, int stop, int rst, int cmp);
    return (32'(rst & 1) << 24) | (32'(stop & 7) << 20) |
           (32'(start & 7) << 16) | 32'(cmp & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // 1 tx_eof, 2 tx_done, 3 rx_active, 4 rx_eof, 5 tx_start, 6 rx_idle
  task automatic strobe(int which);
    @(negedge clk);
    ev_tx_eof    = (which == 1);
    ev_tx_done   = (which == 2);
    ev_rx_active = (which == 3);
    ev_rx_eof    = (which == 4);
    ev_tx_start  = (which == 5);
    ev_rx_idle   = (which == 6);
    @(negedge clk);
    {ev_tx_eof, ev_tx_done, ev_rx_active, ev_rx_eof, ev_tx_start, ev_rx_idle} = '0;
  endtask

  // n tick cycles; pulse sampled 1 ns after each edge
  task automatic ticks(int n, output int first, output int npulse);
    first = 0; npulse = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(posedge clk); #1;
      if (cmp_pulse) begin
        npulse++;
        if (first == 0) first = k;
      end
    end
    @(negedge clk); bit_tick = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      check("R4 idle no pulse", int'(cmp_pulse), 0);
    end
  endtask

  task automatic t_reset;
    int f, n;
    check("R1 reset pulse low", int'(cmp_pulse), 0);
    for (int e = 1; e <= 6; e++) strobe(e);
    ticks(4, f, n);
    check("R1 R11 defaults never arm", n, 0);
  endtask

  task automatic t_basic;
    int f, n;
    write_cfg(mk(1, 0, 0, 3));
    strobe(1);
    ticks(12, f, n);
    check("R5 first pulse tick", f, 4);
    check("R7 self stop single pulse", n, 1);
  endtask

  task automatic t_start_sources;
    int f, n;
    write_cfg(mk(2, 0, 0, 1));
    strobe(1); strobe(3); strobe(4);
    ticks(3, f, n);
    check("R2 unselected no arm", n, 0);
    strobe(2);
    ticks(3, f, n);
    check("R2 tx_done arms", f, 2);
    write_cfg(mk(3, 0, 0, 0));
    strobe(3);
    ticks(2, f, n);
    check("R2 rx_active arms", f, 1);
    write_cfg(mk(4, 0, 0, 0));
    strobe(4);
    ticks(2, f, n);
    check("R2 rx_eof arms", f, 1);
    write_cfg(mk(5, 0, 0, 0));
    for (int e = 1; e <= 6; e++) strobe(e);
    ticks(3, f, n);
    check("R11 unused start code", n, 0);
  endtask

  task automatic t_restart;
    int f, n;
    write_cfg(mk(1, 0, 1, 2));
    strobe(1);
    ticks(9, f, n);
    check("R6 restart first", f, 3);
    check("R6 restart count", n, 3);
  endtask

  task automatic t_stop_sources;
    int f, n;
    write_cfg(mk(1, 1, 0, 5));
    strobe(1); ticks(2, f, n); strobe(5); ticks(8, f, n);
    check("R3 tx_start stops", n, 0);
    write_cfg(mk(1, 2, 0, 5));
    strobe(1); ticks(2, f, n); strobe(3); ticks(8, f, n);
    check("R3 rx_active stops", n, 0);
    write_cfg(mk(1, 3, 0, 5));
    strobe(1); ticks(2, f, n); strobe(6); ticks(8, f, n);
    check("R3 rx_idle stops", n, 0);
    write_cfg(mk(1, 2, 0, 5));
    strobe(1); ticks(2, f, n); strobe(6); ticks(4, f, n);
    check("R3 unselected stop ignored", f, 4);
  endtask

  task automatic t_same_cycle;
    int f, n;
    write_cfg(mk(3, 2, 0, 0));
    strobe(3);
    ticks(4, f, n);
    check("R8 stop beats start", n, 0);
  endtask

  task automatic t_rearm;
    int f, n;
    write_cfg(mk(1, 0, 0, 3));
    strobe(1); ticks(2, f, n);
    check("R9 no early pulse", n, 0);
    strobe(1); ticks(4, f, n);
    check("R9 rearm restarts count", f, 4);
  endtask

  task automatic t_cfg_write;
    int f, n;
    write_cfg(mk(1, 0, 0, 2));
    strobe(1); ticks(1, f, n);
    write_cfg(mk(1, 0, 0, 2));
    ticks(6, f, n);
    check("R10 write disarms", n, 0);
  endtask

  task automatic t_tick_gate;
    int f, n;
    write_cfg(mk(1, 0, 0, 2));
    strobe(1); ticks(1, f, n);
    idle(5);
    ticks(3, f, n);
    check("R4 held across idle", f, 2);
  endtask

  task automatic t_wrap;
    int f, n;
    write_cfg(mk(1, 1, 0, 2));
    strobe(1); ticks(3, f, n);
    check("R7 first match", f, 3);
    ticks(256, f, n);
    check("R7 wrap match tick", f, 256);
    check("R7 wrap single", n, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset_pre();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_basic();
    t_start_sources();
    t_restart();
    t_stop_sources();
    t_same_cycle();
    t_rearm();
    t_cfg_write();
    t_tick_gate();
    t_wrap();
    done = 1'b1;
  end

  task automatic t_reset_pre;
    check("R1 pulse low in reset", int'(cmp_pulse), 0);
  endtask

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule